// File: doc/BRIEF.md
# Input Capture Timer

This block is a free-running up-counter driven by the system clock. It stamps the running count into a capture register whenever a chosen edge appears on an external, asynchronous timer input. Capturing never stops or resets the counter. The counter climbs to a programmable terminal value, then restarts at one and keeps going.

Both kinds of event, a capture and a terminal-count restart, drive a single interrupt line. A cause flag beside that line tells software which event it is serving. A capture sets the flag and a restart clears it. The input passes through a synchroniser chain before edge detection, so the delay from a pin transition to the stored value is a fixed number of clock cycles.

Software programs the block through a write strobe and a select bit. One target holds the terminal value. The other holds an enable bit and an edge-select bit. The count, the captured value and the cause flag are outputs that software can read at any time.

Top module: `capture_timer`

## Requirements
- R1: While reset is asserted and straight after it, the count reads 1, the captured value reads 0, the cause flag reads 0 and the interrupt is low. The terminal value resets to FFFFh and the block starts disabled.
- R2: A write with `wrSel`=1 stores `wrData[0]` as the enable bit. While that bit is 1 the count rises by one on every clock. While it is 0 the count holds.
- R3: A write with `wrSel`=0 stores `wrData` as the terminal value. On the clock after the count equals that value while enabled, the count reads 1, the interrupt pulses high and the cause flag reads 0, unless a capture happens in the same cycle (R8).
- R4: A write with `wrSel`=1 stores `wrData[1]` as the edge select. A value of 0 captures on rising input edges and 1 captures on falling edges. Edges of the other direction are ignored.
- R5: If the input changes before clock edge k, the captured value is the count as it stood just before edge k+2. It is visible after edge k+2, with the default two-stage synchroniser.
- R6: A capture raises the interrupt for exactly the one cycle following it and sets the cause flag to 1. The count continues undisturbed.
- R7: The captured value keeps its contents until the next capture. A terminal-count restart leaves it unchanged.
- R8: When a capture and a terminal-count restart fall on the same cycle, the value is stored, the cause flag reads 1, the count still restarts at 1, and only one one-cycle interrupt pulse is produced.
- R9: While disabled, input edges store nothing and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmrIn | input | 1 | Asynchronous timer input pin |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 terminal value, 1 control bits |
| wrData | input | 16 | Write data |
| countValue | output | 16 | Running count |
| capValue | output | 16 | Last captured count |
| capCause | output | 1 | 1 if the latest interrupt came from a capture |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions check on every cycle that the count steps by one or holds, that it restarts at 1 after the terminal value, that a capture stores the prior count and sets the flag, and that the captured value never moves without a capture. Only the bench scenarios can show the end-to-end latency from a pin transition to the stored value, and that edges of the wrong direction are ignored. The same holds for the coincident capture-and-restart case and for edges that arrive while the block is disabled.

// File: rtl/capt_pkg.sv
package capt_pkg;
  // Strobes handed from the control module to the datapath each cycle.
  typedef struct packed {
    logic countEn;
    logic capture;
  } capStrobe_t;
endpackage

// File: rtl/capt_ctrl.sv
module capt_ctrl
  import capt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tmrIn,
  input  logic       ctlWr,
  input  logic [1:0] ctlBits,
  input  logic       atReload,
  output capStrobe_t strb,
  output logic       enable,
  output logic       capCause,
  output logic       irq
);
  localparam int LAST = SYNC_STAGES - 1;

  logic             polarity;
  logic [LAST:0]    syncQ;
  logic             lastLvl;
  logic             syncLvl;
  logic             edgeHit;
  logic             reloadHit;

  // Control bits: [0] enable, [1] falling-edge select.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable   <= 1'b0;
      polarity <= 1'b0;
    end else if (ctlWr) begin
      enable   <= ctlBits[0];
      polarity <= ctlBits[1];
    end
  end

  // Synchroniser chain followed by one history flop for edge detection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ   <= '0;
      lastLvl <= 1'b0;
    end else begin
      syncQ   <= {syncQ[LAST-1:0], tmrIn};
      lastLvl <= syncQ[LAST];
    end
  end

  assign syncLvl   = syncQ[LAST];
  assign edgeHit   = polarity ? (lastLvl & ~syncLvl) : (syncLvl & ~lastLvl);
  assign reloadHit = enable & atReload;

  always_comb begin
    strb.countEn = enable;
    strb.capture = enable & edgeHit;
  end

  // One interrupt pulse per cycle with any event; a capture wins the flag.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq      <= 1'b0;
      capCause <= 1'b0;
    end else begin
      irq <= strb.capture | reloadHit;
      if (strb.capture)  capCause <= 1'b1;
      else if (reloadHit) capCause <= 1'b0;
    end
  end
endmodule

// File: rtl/capt_datapath.sv
module capt_datapath
  import capt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reloadWr,
  input  logic [W-1:0] wrData,
  input  capStrobe_t   strb,
  output logic [W-1:0] countValue,
  output logic [W-1:0] capValue,
  output logic [W-1:0] reloadVal,
  output logic         atReload
);
  localparam logic [W-1:0] WRAP_VALUE   = W'(1);
  localparam logic [W-1:0] RELOAD_RESET = '1;

  assign atReload = (countValue == reloadVal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reloadVal <= RELOAD_RESET;
    else if (reloadWr) reloadVal <= wrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) countValue <= WRAP_VALUE;
    else if (strb.countEn) countValue <= atReload ? WRAP_VALUE : countValue + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) capValue <= '0;
    else if (strb.capture) capValue <= countValue;
  end
endmodule

// File: rtl/capture_timer.sv
module capture_timer
  import capt_pkg::*;
#(
  parameter int COUNT_WIDTH = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tmrIn,
  input  logic                   wrEn,
  input  logic                   wrSel,
  input  logic [COUNT_WIDTH-1:0] wrData,
  output logic [COUNT_WIDTH-1:0] countValue,
  output logic [COUNT_WIDTH-1:0] capValue,
  output logic                   capCause,
  output logic                   irq
);
  capStrobe_t             strb;
  logic                   ctrlEnable;
  logic                   atReload;
  logic [COUNT_WIDTH-1:0] reloadVal;
  logic                   ctlWr;
  logic                   reloadWr;

  assign ctlWr    = wrEn & wrSel;
  assign reloadWr = wrEn & ~wrSel;

  capt_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tmrIn    (tmrIn),
    .ctlWr    (ctlWr),
    .ctlBits  (wrData[1:0]),
    .atReload (atReload),
    .strb     (strb),
    .enable   (ctrlEnable),
    .capCause (capCause),
    .irq      (irq)
  );

  capt_datapath #(.W(COUNT_WIDTH)) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reloadWr   (reloadWr),
    .wrData     (wrData),
    .strb       (strb),
    .countValue (countValue),
    .capValue   (capValue),
    .reloadVal  (reloadVal),
    .atReload   (atReload)
  );
endmodule

// File: rtl/capt_checker.sv
module capt_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         irq,
  input logic         capCause,
  input logic [W-1:0] capValue,
  input logic [W-1:0] countValue,
  input logic [W-1:0] reloadVal,
  input logic         ctrlEnable,
  input logic         capStrobe
);
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlEnable && countValue != reloadVal) |=> countValue == $past(countValue) + W'(1));

  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrlEnable |=> $stable(countValue));

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlEnable && countValue == reloadVal) |=> (countValue == W'(1) && irq));

  p_flag_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlEnable && countValue == reloadVal && !capStrobe) |=> !capCause);

  p_cap_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
    capStrobe |=> (capValue == $past(countValue) && irq && capCause));

  p_cap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !capStrobe |=> $stable(capValue));

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrlEnable |=> !irq);
endmodule

bind capture_timer capt_checker #(.W(COUNT_WIDTH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq        (irq),
  .capCause   (capCause),
  .capValue   (capValue),
  .countValue (countValue),
  .reloadVal  (reloadVal),
  .ctrlEnable (ctrlEnable),
  .capStrobe  (strb.capture)
);

// File: tb/capture_timer_tb_top.sv
module capture_timer_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tmrIn = 1'b0;
  logic         wrEn = 1'b0;
  logic         wrSel = 1'b0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] countValue;
  logic [W-1:0] capValue;
  logic         capCause;
  logic         irq;

  always #10 clk = ~clk;

  capture_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tmrIn(tmrIn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .countValue(countValue), .capValue(capValue),
    .capCause(capCause), .irq(irq)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit runMon = 1'b0;

  typedef struct {
    logic [W-1:0] value;
    int           due;
  } capItem_t;
  capItem_t expQ[$];

  // Reference state derived from the requirements.
  logic         mEn, mPol, mWrapSeen;
  logic [W-1:0] mReload, mCount, lastCap;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] nx(input logic [W-1:0] c);
    return (c == mReload) ? W'(1) : c + W'(1);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      mEn <= 1'b0; mPol <= 1'b0; mReload <= '1; mCount <= W'(1); mWrapSeen <= 1'b0;
    end else begin
      if (wrEn && wrSel) begin mEn <= wrData[0]; mPol <= wrData[1]; end
      else if (wrEn) mReload <= wrData;
      mWrapSeen <= mEn && (mCount == mReload);
      if (mEn) mCount <= nx(mCount);
    end
  end

  // Monitor: pops expected captures when they fall due.
  always @(negedge clk) begin
    if (rst_n && runMon) begin
      bit capDue;
      string irqTag;
      capDue = (expQ.size() > 0) && (expQ[0].due == cyc);
      irqTag = capDue ? (mWrapSeen ? "R8" : "R6") : (mWrapSeen ? "R3" : (mEn ? "R6" : "R9"));
      check(irq == (capDue || mWrapSeen), irqTag, "irq", irq, capDue || mWrapSeen);
      check(countValue == mCount, "R2", "count", countValue, mCount);
      if (capDue) begin
        check(capValue == expQ[0].value, "R5", "captured value", capValue, expQ[0].value);
        check(capCause == 1'b1, mWrapSeen ? "R8" : "R6", "cause flag", capCause, 1);
        lastCap = expQ[0].value;
        void'(expQ.pop_front());
      end else begin
        check(capValue == lastCap, "R7", "captured value held", capValue, lastCap);
        if (mWrapSeen) check(capCause == 1'b0, "R3", "cause flag", capCause, 0);
      end
      if (mWrapSeen) check(countValue == W'(1), "R3", "restart value", countValue, 1);
    end
  end

  // Driver: change the pin right after a falling clock edge.
  task automatic setInput(input logic lvl);
    bit hit;
    hit = mPol ? (tmrIn && !lvl) : (!tmrIn && lvl);
    tmrIn = lvl;
    if (hit && mEn) expQ.push_back('{nx(nx(mCount)), cyc + 3});
  endtask

  task automatic writeReg(input logic sel, input logic [W-1:0] data);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    lastCap = '0;
    idle(3);
    check(countValue == W'(1), "R1", "count in reset", countValue, 1);
    check(capValue == '0, "R1", "capture in reset", capValue, 0);
    check(capCause == 1'b0 && irq == 1'b0, "R1", "flag/irq in reset", {capCause, irq}, 0);
    rst_n = 1'b1;
    idle(2);
    check(countValue == W'(1) && irq == 1'b0, "R1", "idle after reset", countValue, 1);
    runMon = 1'b1;

    // Rising-edge captures, falling edge ignored, restart at 40 (R2 R3 R4 R5 R7).
    writeReg(1'b0, W'(40));
    writeReg(1'b1, W'(1));
    idle(5);
    setInput(1'b1);
    idle(8);
    setInput(1'b0);
    idle(50);

    // Falling-edge select; rising edges ignored, back-to-back edges (R4).
    writeReg(1'b1, W'(3));
    idle(2);
    setInput(1'b1);
    idle(4);
    setInput(1'b0);
    idle(6);
    setInput(1'b1);
    idle(1);
    setInput(1'b0);
    idle(6);

    // Capture on the restart cycle (R8).
    setInput(1'b1);
    idle(2);
    while (nx(nx(mCount)) != mReload) @(negedge clk);
    setInput(1'b0);
    idle(50);

    // Disabled: edges ignored, count frozen (R9 R2).
    writeReg(1'b1, W'(2));
    idle(2);
    setInput(1'b1);
    idle(3);
    setInput(1'b0);
    idle(6);

    // Re-enable with rising select.
    writeReg(1'b1, W'(1));
    idle(2);
    setInput(1'b1);
    idle(6);
    setInput(1'b0);
    idle(8);

    check(expQ.size() == 0, "R5", "pending captures", expQ.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule